// File: doc/BRIEF.md
# Strobe-Driven FIFO Buffer

A first-in first-out store of 256 words by 9 bits (depth is a parameter and may be 512 or 1024) that is paced by two active-low strobes rather than by clock enables. The write strobe and the read strobe are brought into the system clock domain through flop synchronisers. Each falling and rising edge then becomes a one-cycle event. A word is stored when the write strobe rises. A word is presented while the read strobe is low and is consumed when that strobe rises.

The block reports occupancy through three active-low flags: empty, full and half-full. A retransmit input rewinds the read side to the first location so that stored data can be read again. The data output is paired with an output-enable. An external three-state buffer can use it to release a shared bus whenever no read is in progress.

Two boundary cases are defined. When the read strobe is held low on an empty buffer, the first word written appears at the output and is consumed when the read strobe rises. This is read flow-through. When the write strobe is held low on a full buffer, a completed read makes room and the pending word is stored when the write strobe rises. This is write flow-through.

Top module: `strobe_fifo`

## Requirements
- R1: A synchronous active-high `rst` sets the buffer empty with both pointers at zero. After it, `empty_n`=0, `full_n`=1, `half_n`=1 and `dout_oe`=0.
- R2: Each complete low-then-high pulse of `wr_n` stores `din`, as sampled at the rising edge of the strobe, exactly once. The write pointer moves only on such a rising edge.
- R3: A write pulse that ends while the buffer holds DEPTH words is ignored. The stored contents and the count are unchanged.
- R4: While `rd_n` is low and a word is stored, `dout_oe`=1 and `dout` shows the oldest stored word. The rising edge of `rd_n` removes that word, and `dout_oe` returns to 0.
- R5: A read pulse on an empty buffer with no write during it removes nothing, and `dout_oe` stays 0.
- R6: `empty_n`=0 exactly when no word is stored, and `full_n`=0 exactly when DEPTH words are stored. The brief flow-through exceptions in R8 and R9 are the only departures.
- R7: `half_n`=0 exactly when the stored count is at least DEPTH/2+1.
- R8: Read flow-through. With `rd_n` held low on an empty buffer, the word from the next write drives `dout` with `dout_oe`=1. `empty_n` rises for one cycle and then returns low. Raising `rd_n` consumes the word.
- R9: Write flow-through. With `wr_n` held low on a full buffer, a completed read makes `full_n` rise for one cycle and then return low. Raising `wr_n` stores the pending word as the newest entry.
- R10: A one-cycle `retx` pulse moves the read pointer back to location 0 and leaves the write pointer unchanged. All words written since reset can then be read again in order, provided fewer than DEPTH+1 words have been written. The flags follow the restored count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write strobe, active low; a word is stored on its rising edge |
| rd_n | input | 1 | Read strobe, active low; a word is consumed on its rising edge |
| retx | input | 1 | Retransmit pulse, active high, synchronous to clk |
| din | input | WIDTH | Write data |
| dout | output | WIDTH | Read data, valid while dout_oe is high |
| dout_oe | output | 1 | Output enable for an external three-state driver |
| empty_n | output | 1 | Empty flag, active low |
| full_n | output | 1 | Full flag, active low |
| half_n | output | 1 | Half-full flag, active low |

## Verification
The bench runs a 16-word build with a queue model. It sweeps the count through every value from 0 to 16 and back with distinct data words, so each flag threshold and the storage order are checked at every occupancy. Extra writes into a full buffer and reads from an empty one show whether a strobe pulse at a boundary is dropped or wrongly acted on. The two flow-through sequences hold one strobe low across the opposite operation, which separates the one-cycle flag pulse from a flag that stays put. Retransmits after partial reads, on both sides of the half-full mark, show whether the read pointer is rewound without disturbing the write side.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

  // Events derived from one synchronised active-low strobe
  typedef struct packed {
    logic low;   // strobe level is low after synchronisation
    logic fall;  // one-cycle pulse on the HIGH-to-LOW change
    logic rise;  // one-cycle pulse on the LOW-to-HIGH change
  } strobe_ev_t;

  function automatic int half_mark(input int depth);
    return depth / 2 + 1;
  endfunction

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge
  import strobe_fifo_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe_n,
  output strobe_ev_t ev
);

  // chain[0] is the first synchroniser flop; chain[STAGES] holds the previous level
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-1:0], strobe_n};
  end

  logic lvl, prev;
  assign lvl  = chain[STAGES-1];
  assign prev = chain[STAGES];

  always_comb begin
    ev.low  = !lvl;
    ev.fall = prev && !lvl;
    ev.rise = !prev && lvl;
  end

endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int WIDTH = 9,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  localparam int WORDS = 1 << AW;

  logic [WIDTH-1:0] mem [WORDS];

  // Simple dual-port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/fifo_flags.sv
module fifo_flags #(
  parameter int DEPTH = 256,
  parameter int CW    = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cnt_nx,
  input  logic          rd_wait,
  input  logic          wr_wait,
  output logic          empty_q,
  output logic          full_q,
  output logic          half_q
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] LAST_CNT = CW'(DEPTH - 1);
  localparam logic [CW-1:0] HALF_CNT = CW'(strobe_fifo_pkg::half_mark(DEPTH));
  localparam logic [CW-1:0] ONE_CNT  = CW'(1);

  // The flow-through terms re-assert a flag one cycle after it dropped,
  // while the opposite strobe still holds a pending operation.
  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      empty_q <= (cnt_nx == '0) ||
                 (rd_wait && cnt == ONE_CNT && cnt_nx == ONE_CNT);
      full_q  <= (cnt_nx == FULL_CNT) ||
                 (wr_wait && cnt == LAST_CNT && cnt_nx == LAST_CNT);
      half_q  <= (cnt_nx >= HALF_CNT);
    end
  end

  AST_EMPTY_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |-> empty_q);                                     // R6
  AST_FULL_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    (cnt == FULL_CNT) |-> full_q);                                // R6
  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (rst)
    !(empty_q && full_q));                                        // R6
  AST_HALF_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    half_q |-> !empty_q);                                         // R7

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH       = 256,
  parameter int WIDTH       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             retx,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dout_oe,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  // Strobe synchronisation: index 0 = write, index 1 = read
  logic [1:0]  strobe_in;
  strobe_ev_t  ev [2];
  strobe_ev_t  wr_ev, rd_ev;

  assign strobe_in = {rd_n, wr_n};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    strobe_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst      (rst),
      .strobe_n (strobe_in[g]),
      .ev       (ev[g])
    );
  end

  assign wr_ev = ev[0];
  assign rd_ev = ev[1];

  // Pointers carry one extra bit so that full and empty are distinct
  logic [CW-1:0] wptr, rptr, wptr_nx, rptr_nx, cnt, cnt_nx;
  logic          rd_commit, wr_commit;
  logic          rd_wait, wr_wait;

  assign cnt       = wptr - rptr;
  assign rd_commit = rd_ev.rise && (cnt != '0) && !retx;
  assign wr_commit = wr_ev.rise && ((cnt < FULL_CNT) || rd_commit);
  assign wptr_nx   = wptr + CW'(wr_commit);
  assign rptr_nx   = retx ? '0 : rptr + CW'(rd_commit);
  assign cnt_nx    = wptr_nx - rptr_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      wptr <= wptr_nx;
      rptr <= rptr_nx;
    end
  end

  // Flow-through tracking: a strobe that fell on a boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_wait <= 1'b0;
      wr_wait <= 1'b0;
    end else begin
      if (rd_ev.fall)      rd_wait <= (cnt == '0);
      else if (rd_ev.rise) rd_wait <= 1'b0;
      if (wr_ev.fall)      wr_wait <= (cnt == FULL_CNT);
      else if (wr_ev.rise) wr_wait <= 1'b0;
    end
  end

  fifo_store #(.WIDTH(WIDTH), .AW(AW)) u_store (
    .clk   (clk),
    .we    (wr_commit),
    .waddr (wptr[AW-1:0]),
    .wdata (din),
    .raddr (rptr[AW-1:0]),
    .rdata (dout)
  );

  // Output enable registered in step with the RAM read port
  logic oe_q;
  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= rd_ev.low && (cnt != '0);
  end
  assign dout_oe = oe_q;

  logic empty_q, full_q, half_q;

  fifo_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .cnt     (cnt),
    .cnt_nx  (cnt_nx),
    .rd_wait (rd_wait),
    .wr_wait (wr_wait),
    .empty_q (empty_q),
    .full_q  (full_q),
    .half_q  (half_q)
  );

  assign empty_n = !empty_q;
  assign full_n  = !full_q;
  assign half_n  = !half_q;

  AST_WPTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_ev.rise |=> $stable(wptr));                               // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_CNT);                                             // R3
  AST_RPTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rd_ev.rise && !retx) |=> $stable(rptr));                    // R4
  AST_OE_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> (cnt != '0) || $past(retx));                      // R4
  AST_RETX_REWIND: assert property (@(posedge clk) disable iff (rst)
    retx |=> (rptr == '0) && $stable(wptr) || $past(wr_commit));  // R10

endmodule

// File: tb/strobe_fifo_test.sv
`timescale 1ns/1ps
module strobe_fifo_test;

  localparam int D    = 16;
  localparam int W    = 9;
  localparam int HALF = D / 2 + 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_n = 1'b1, rd_n = 1'b1, retx = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic         dout_oe, empty_n, full_n, half_n;

  strobe_fifo #(.DEPTH(D), .WIDTH(W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .wr_n(wr_n), .rd_n(rd_n), .retx(retx),
    .din(din), .dout(dout), .dout_oe(dout_oe),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
  );

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int model[$];
  bit saw_empty_hi, saw_full_hi;

  always @(negedge clk) begin
    if (empty_n) saw_empty_hi = 1'b1;
    if (full_n)  saw_full_hi  = 1'b1;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_flags(input string tag);
    int n = model.size();
    check({tag, " R6 empty_n"}, int'(empty_n), int'(n != 0));
    check({tag, " R6 full_n"},  int'(full_n),  int'(n != D));
    check({tag, " R7 half_n"},  int'(half_n),  int'(n < HALF));
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; wr_n = 1'b1; rd_n = 1'b1; retx = 1'b0;
    cyc(3); rst = 1'b0; cyc(1);
    model.delete();
  endtask

  task automatic wr(input int v);
    @(negedge clk); din = W'(v); wr_n = 1'b0;
    cyc(4); wr_n = 1'b1; cyc(4);
    if (model.size() < D) model.push_back(v & ((1 << W) - 1));
  endtask

  task automatic rd(input string tag);
    @(negedge clk); rd_n = 1'b0; cyc(4);
    if (model.size() > 0) begin
      check({tag, " R4 oe"},   int'(dout_oe), 1);
      check({tag, " R4 data"}, int'(dout),    model[0]);
    end else begin
      check({tag, " R5 oe on empty"}, int'(dout_oe), 0);
    end
    rd_n = 1'b1; cyc(4);
    check({tag, " R4 oe off"}, int'(dout_oe), 0);
    if (model.size() > 0) void'(model.pop_front());
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    // R1 reset state
    do_reset();
    check("R1 empty_n", int'(empty_n), 0);
    check("R1 full_n",  int'(full_n),  1);
    check("R1 half_n",  int'(half_n),  1);
    check("R1 oe",      int'(dout_oe), 0);

    // R2/R6/R7 fill sweep through every count
    for (int i = 0; i < D; i++) begin
      wr(i * 37 + 5);
      check_flags("R2 fill");
      check("R2 count", model.size(), i + 1);
    end

    // R3 write into full buffer is dropped
    wr(9'h1AA);
    check_flags("R3 after extra write");

    // R4 drain sweep with data order
    for (int i = 0; i < D; i++) begin
      rd("R4 drain");
      check_flags("R4 drain");
    end
    check("R3 extra word absent", model.size(), 0);

    // R5 read pulse on empty buffer
    rd("R5 empty read");
    check("R5 still empty", int'(empty_n), 0);
    wr(9'h055);
    rd("R5 next word intact");
    check_flags("R5 after");

    // R8 read flow-through
    do_reset();
    @(negedge clk); rd_n = 1'b0; cyc(4);
    check("R8 oe before write", int'(dout_oe), 0);
    #1 saw_empty_hi = 1'b0;
    @(negedge clk); din = 9'h13C; wr_n = 1'b0; cyc(4); wr_n = 1'b1; cyc(5);
    check("R8 empty pulse seen", int'(saw_empty_hi), 1);
    check("R8 empty_n back low", int'(empty_n), 0);
    check("R8 oe", int'(dout_oe), 1);
    check("R8 data", int'(dout), 9'h13C);
    rd_n = 1'b1; cyc(4);
    check("R8 oe after rise", int'(dout_oe), 0);
    check("R8 empty after rise", int'(empty_n), 0);
    wr(9'h0F1);
    rd("R8 pointer advanced");

    // R9 write flow-through
    do_reset();
    for (int i = 0; i < D; i++) wr(i + 100);
    @(negedge clk); din = 9'h1E7; wr_n = 1'b0; cyc(4);
    check("R9 full while pending", int'(full_n), 0);
    #1 saw_full_hi = 1'b0;
    rd("R9 read during pending");
    check("R9 full pulse seen", int'(saw_full_hi), 1);
    check("R9 full_n back low", int'(full_n), 0);
    wr_n = 1'b1; cyc(4);
    model.push_back(9'h1E7);
    check_flags("R9 after store");
    for (int i = 0; i < D; i++) rd("R9 drain");
    check_flags("R9 drained");

    // R10 retransmit below half mark
    do_reset();
    for (int i = 0; i < 6; i++) wr(200 + i);
    for (int i = 0; i < 3; i++) rd("R10 partial");
    @(negedge clk); retx = 1'b1; @(negedge clk); retx = 1'b0; cyc(2);
    model.delete();
    for (int i = 0; i < 6; i++) model.push_back(200 + i);
    check_flags("R10 rewound 6");
    for (int i = 0; i < 6; i++) rd("R10 replay");

    // R10 retransmit crossing the half mark
    do_reset();
    for (int i = 0; i < HALF + 1; i++) wr(300 + i * 3);
    for (int i = 0; i < 5; i++) rd("R10 partial2");
    check_flags("R10 before rewind");
    @(negedge clk); retx = 1'b1; @(negedge clk); retx = 1'b0; cyc(2);
    model.delete();
    for (int i = 0; i < HALF + 1; i++) model.push_back((300 + i * 3) & 9'h1FF);
    check_flags("R10 rewound half");
    for (int i = 0; i < HALF + 1; i++) rd("R10 replay2");

    // R1 reset in mid operation
    for (int i = 0; i < 3; i++) wr(i + 1);
    do_reset();
    check("R1 mid empty_n", int'(empty_n), 0);
    check("R1 mid full_n",  int'(full_n),  1);
    check("R1 mid half_n",  int'(half_n),  1);
    rd("R1 read after reset");

    report();
  end

endmodule